// File: doc/BRIEF.md
# Majority-Vote Median Filter

This block takes a stream of unsigned samples, keeps the most recent M of them in a shift window, and reports their median. It uses no comparators and no sorting network. The result is built one bit at a time, from the most significant bit down. Each bit is a majority vote over one bit column of the window.

After the top bit is settled, a sample whose upper bits already differ from the median prefix is known to lie strictly above or below the median. That sample then votes with its first differing bit in every lower column. A sample that still matches the prefix votes with its own bit. Each sample carries a "still matches" flag and a "side" bit from column to column, so this correction holds at any depth.

Two engines are available. The chain engine lays out all N vote stages. They can be registered, giving one result per cycle with an N-cycle latency, or left combinational, giving a latency of one cycle. The serial engine reuses a single vote stage over N cycles after a start pulse. M must be odd, so a vote can never tie.

Top module: `majority_median`

## Requirements
- R1: After reset, and until the first accepted sample has been evaluated, `med_valid` is 0 and `med_out` is 0. The window starts with M zero samples.
- R2: Each clock edge with `smp_valid` high shifts `smp_in` into the window and drops the oldest of the M samples. An edge with `smp_valid` low leaves the window unchanged.
- R3: A reported result equals the ((M+1)/2)-th smallest of the M window samples, compared as unsigned values.
- R4: Bit N-1 of the result is 1 exactly when more than M/2 window samples have bit N-1 set.
- R5: In the chain engine with stage registers (ENGINE=ENG_CHAIN, PIPE=1), `med_valid` is high for one cycle per accepted sample, N clock edges after the edge that accepted it. Samples may be accepted on every cycle.
- R6: In the chain engine without stage registers (PIPE=0), `med_valid` and the result follow one clock edge after the accepting edge.
- R7: In the serial engine (ENGINE=ENG_SERIAL), an `eval_start` sampled while idle evaluates the window as it stands at that edge. `med_valid` pulses for one cycle, N edges later, together with the result. A start that arrives during an evaluation is ignored, and samples accepted during an evaluation do not change its result.
- R8: Windows with repeated values, and windows of all-zero or all-ones samples, give the correct median.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_in | input | N | Incoming unsigned sample |
| smp_valid | input | 1 | Shifts `smp_in` into the window on this edge |
| eval_start | input | 1 | Starts an evaluation in the serial engine; unused by the chain engine |
| med_out | output | N | Median of the evaluated window |
| med_valid | output | 1 | One-cycle strobe marking a new `med_out` |

## Verification
The hardest case to reach is a window in which samples drop out of the prefix match at different depths, on both sides of the median. Only then do the forced "above" and "below" votes outweigh a column's own bits. The stimulus reaches it with values such as 0x7F, 0x80 and 0x81 sitting next to 0x07 and 0xFF. Their prefixes agree for several bits and then split late.

The serial engine's snapshot is tested by pushing a new sample, and issuing a second start, while an evaluation is in flight. The check then confirms that the result matches the window captured at the first start.

// File: rtl/mm_pkg.sv
package mm_pkg;
  // Selects how the vote stages are arranged.
  typedef enum logic [0:0] {
    ENG_CHAIN  = 1'b0,   // N stages laid out in a row
    ENG_SERIAL = 1'b1    // one stage reused over N cycles
  } engine_e;
endpackage

// File: rtl/mm_vote_stage.sv
// One bit column of the median search: corrects each sample's bit by its
// prefix state, takes the majority, and updates the per-sample state.
module mm_vote_stage #(
  parameter int M = 5
) (
  input  logic [M-1:0] col,
  input  logic [M-1:0] eq_in,
  input  logic [M-1:0] side_in,
  output logic         bit_out,
  output logic [M-1:0] eq_out,
  output logic [M-1:0] side_out
);
  localparam int CW   = $clog2(M + 1);
  localparam int HALF = M / 2;

  logic [M-1:0]  eff;
  logic [CW-1:0] ones;

  // A diverged sample keeps voting with the bit where it first split.
  assign eff = (eq_in & col) | (~eq_in & side_in);

  always_comb begin
    ones = '0;
    for (int i = 0; i < M; i++) begin
      ones = ones + CW'(eff[i]);
    end
  end

  assign bit_out = (ones > CW'(HALF));

  always_comb begin
    for (int i = 0; i < M; i++) begin
      eq_out[i]   = eq_in[i] & (col[i] == bit_out);
      side_out[i] = eq_in[i] ? col[i] : side_in[i];
    end
  end
endmodule

// File: rtl/mm_window.sv
// Sample window: newest at index 0, oldest at index M-1.
module mm_window #(
  parameter int M = 5,
  parameter int N = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift,
  input  logic [N-1:0]        din,
  output logic [M-1:0][N-1:0] win,
  output logic                fresh
);
  logic [M-1:0][N-1:0] win_q, win_d;
  logic                fresh_q;

  always_comb begin
    win_d = win_q;
    if (shift) begin
      win_d[0] = din;
      for (int i = 1; i < M; i++) begin
        win_d[i] = win_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= shift;
      if (shift) begin
        win_q <= win_d;
      end
    end
  end

  assign win   = win_q;
  assign fresh = fresh_q;

  // R2: without a shift the window holds its contents
  p_window_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(win_q));
endmodule

// File: rtl/mm_chain.sv
// N vote stages in a row, each optionally followed by a register.
module mm_chain #(
  parameter int M    = 5,
  parameter int N    = 8,
  parameter bit PIPE = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [M-1:0][N-1:0] win,
  input  logic                win_vld,
  output logic [N-1:0]        med,
  output logic                med_vld
);
  localparam int HALF = M / 2;

  logic [M-1:0][N-1:0] w_s    [N+1];
  logic [M-1:0]        eq_s   [N+1];
  logic [M-1:0]        side_s [N+1];
  logic [N-1:0]        acc_s  [N+1];
  logic                v_s    [N+1];

  assign w_s[0]    = win;
  assign eq_s[0]   = '1;
  assign side_s[0] = '0;
  assign acc_s[0]  = '0;
  assign v_s[0]    = win_vld;

  for (genvar k = 0; k < N; k++) begin : g_stage
    localparam int BIT = N - 1 - k;
    logic [M-1:0] col, eq_n, side_n;
    logic         b;
    logic [N-1:0] acc_n;

    always_comb begin
      for (int i = 0; i < M; i++) begin
        col[i] = w_s[k][i][BIT];
      end
    end

    mm_vote_stage #(.M(M)) u_vote (
      .col     (col),
      .eq_in   (eq_s[k]),
      .side_in (side_s[k]),
      .bit_out (b),
      .eq_out  (eq_n),
      .side_out(side_n)
    );

    always_comb begin
      acc_n      = acc_s[k];
      acc_n[BIT] = b;
    end

    if (PIPE) begin : g_reg
      logic [M-1:0][N-1:0] w_r;
      logic [M-1:0]        eq_r, side_r;
      logic [N-1:0]        acc_r;
      logic                v_r;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          w_r    <= '0;
          eq_r   <= '1;
          side_r <= '0;
          acc_r  <= '0;
          v_r    <= 1'b0;
        end else begin
          v_r <= v_s[k];
          if (v_s[k]) begin
            w_r    <= w_s[k];
            eq_r   <= eq_n;
            side_r <= side_n;
            acc_r  <= acc_n;
          end
        end
      end

      assign w_s[k+1]    = w_r;
      assign eq_s[k+1]   = eq_r;
      assign side_s[k+1] = side_r;
      assign acc_s[k+1]  = acc_r;
      assign v_s[k+1]    = v_r;
    end else begin : g_wire
      assign w_s[k+1]    = w_s[k];
      assign eq_s[k+1]   = eq_n;
      assign side_s[k+1] = side_n;
      assign acc_s[k+1]  = acc_n;
      assign v_s[k+1]    = v_s[k];
    end

    // R3: at no depth can more than M/2 samples lie above the median prefix
    p_balance_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~eq_s[k+1] & side_s[k+1]) <= HALF);
    // R3: nor more than M/2 below it
    p_balance_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~eq_s[k+1] & ~side_s[k+1]) <= HALF);
  end

  if (PIPE) begin : g_out_pipe
    assign med     = acc_s[N];
    assign med_vld = v_s[N];
  end else begin : g_out_reg
    logic [N-1:0] med_q;
    logic         vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        med_q <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= v_s[N];
        if (v_s[N]) begin
          med_q <= acc_s[N];
        end
      end
    end

    assign med     = med_q;
    assign med_vld = vld_q;
  end

  // R3: the median is one of the window samples, so some sample matches it fully
  p_median_is_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    v_s[N] |-> (eq_s[N] != '0));
endmodule

// File: rtl/mm_serial.sv
// One vote stage reused over N cycles on a snapshot of the window.
module mm_serial #(
  parameter int M = 5,
  parameter int N = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [M-1:0][N-1:0] win,
  input  logic                start,
  output logic [N-1:0]        med,
  output logic                done
);
  localparam int CNT_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

  logic [M-1:0][N-1:0] work_q, work_d;
  logic [M-1:0]        eq_q, eq_d, side_q, side_d;
  logic [N-1:0]        acc_q, acc_d, med_q, med_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                busy_q, busy_d, done_q, done_d;

  logic [M-1:0] col, eq_n, side_n;
  logic         b;
  logic         last;

  always_comb begin
    for (int i = 0; i < M; i++) begin
      col[i] = work_q[i][N-1];
    end
  end

  mm_vote_stage #(.M(M)) u_vote (
    .col     (col),
    .eq_in   (eq_q),
    .side_in (side_q),
    .bit_out (b),
    .eq_out  (eq_n),
    .side_out(side_n)
  );

  assign last = (cnt_q == LAST);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    work_d = work_q;
    eq_d   = eq_q;
    side_d = side_q;
    acc_d  = acc_q;
    med_d  = med_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        work_d = win;
        eq_d   = '1;
        side_d = '0;
        acc_d  = '0;
      end
    end else begin
      for (int i = 0; i < M; i++) begin
        work_d[i] = work_q[i] << 1;
      end
      eq_d   = eq_n;
      side_d = side_n;
      acc_d  = {acc_q[N-2:0], b};
      cnt_d  = cnt_q + 1'b1;
      if (last) begin
        busy_d = 1'b0;
        med_d  = {acc_q[N-2:0], b};
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      work_q <= '0;
      eq_q   <= '1;
      side_q <= '0;
      acc_q  <= '0;
      med_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      work_q <= work_d;
      eq_q   <= eq_d;
      side_q <= side_d;
      acc_q  <= acc_d;
      med_q  <= med_d;
      done_q <= done_d;
    end
  end

  assign med  = med_q;
  assign done = done_q;

  // R7: completion is a single-cycle strobe
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R7: completion only ends an evaluation that was running
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));
  // R7: a start during an evaluation does not restart the step count
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last && start) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
  // R3: after the last column at least one sample equals the median
  p_serial_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && last) |-> (eq_n != '0));
endmodule

// File: rtl/majority_median.sv
module majority_median #(
  parameter int              M      = 5,
  parameter int              N      = 8,
  parameter mm_pkg::engine_e ENGINE = mm_pkg::ENG_CHAIN,
  parameter bit              PIPE   = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] smp_in,
  input  logic         smp_valid,
  input  logic         eval_start,
  output logic [N-1:0] med_out,
  output logic         med_valid
);
  logic [1:0]          rs_q;
  logic                rst_i_n;
  logic [M-1:0][N-1:0] win;
  logic                win_fresh;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_i_n = rs_q[1];

  mm_window #(.M(M), .N(N)) u_win (
    .clk  (clk),
    .rst_n(rst_i_n),
    .shift(smp_valid),
    .din  (smp_in),
    .win  (win),
    .fresh(win_fresh)
  );

  if (ENGINE == mm_pkg::ENG_SERIAL) begin : g_serial
    logic unused_fresh;
    assign unused_fresh = win_fresh;

    mm_serial #(.M(M), .N(N)) u_eng (
      .clk  (clk),
      .rst_n(rst_i_n),
      .win  (win),
      .start(eval_start),
      .med  (med_out),
      .done (med_valid)
    );
  end else begin : g_chain
    logic unused_start;
    assign unused_start = eval_start;

    mm_chain #(.M(M), .N(N), .PIPE(PIPE)) u_eng (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .win    (win),
      .win_vld(win_fresh),
      .med    (med_out),
      .med_vld(med_valid)
    );
  end

  // R1: outputs are quiet on the first cycle after the internal reset releases
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_i_n) |-> (!med_valid && med_out == '0));
endmodule

// File: tb/majority_median_test.sv
`timescale 1ns/1ps
module majority_median_test;
  localparam int M = 5;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] smp_in;
  logic         smp_valid;
  logic         eval_start;
  logic [N-1:0] p_out, c_out, s_out;
  logic         p_vld, c_vld, s_vld;

  int checks = 0;
  int fails  = 0;

  logic [N-1:0] bw      [M];
  logic [N-1:0] stim    [16];
  logic [N-1:0] exp_med [16];
  bit           exp_msb [16];

  always #4 clk = ~clk;

  majority_median #(.M(M), .N(N), .ENGINE(mm_pkg::ENG_CHAIN), .PIPE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_valid(smp_valid),
    .eval_start(eval_start), .med_out(p_out), .med_valid(p_vld));

  majority_median #(.M(M), .N(N), .ENGINE(mm_pkg::ENG_CHAIN), .PIPE(1'b0)) uut_cmb (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_valid(smp_valid),
    .eval_start(eval_start), .med_out(c_out), .med_valid(c_vld));

  majority_median #(.M(M), .N(N), .ENGINE(mm_pkg::ENG_SERIAL), .PIPE(1'b1)) uut_ser (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_valid(smp_valid),
    .eval_start(eval_start), .med_out(s_out), .med_valid(s_vld));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] ref_median();
    logic [N-1:0] t [M];
    logic [N-1:0] x;
    for (int i = 0; i < M; i++) t[i] = bw[i];
    for (int a = 0; a < M; a++)
      for (int j = 0; j < M - 1; j++)
        if (t[j] > t[j+1]) begin x = t[j]; t[j] = t[j+1]; t[j+1] = x; end
    return t[M/2];
  endfunction

  function automatic bit ref_msb();
    int n = 0;
    for (int i = 0; i < M; i++) n += int'(bw[i][N-1]);
    return n > M / 2;
  endfunction

  task automatic model_push(input logic [N-1:0] v);
    for (int i = M - 1; i > 0; i--) bw[i] = bw[i-1];
    bw[0] = v;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(p_vld == 1'b0, "R1 pipe valid", int'(p_vld), 0);
    chk(p_out == '0,   "R1 pipe out",   int'(p_out), 0);
    chk(c_vld == 1'b0, "R1 comb valid", int'(c_vld), 0);
    chk(c_out == '0,   "R1 comb out",   int'(c_out), 0);
    chk(s_vld == 1'b0, "R1 serial valid", int'(s_vld), 0);
    chk(s_out == '0,   "R1 serial out", int'(s_out), 0);
  endtask

  // Streams stim[0..cnt-1] back to back and checks both chain engines.
  task automatic t_stream(input int cnt, input string tag);
    for (int i = 0; i < cnt; i++) begin
      model_push(stim[i]);
      exp_med[i] = ref_median();
      exp_msb[i] = ref_msb();
    end
    for (int c = 0; c < cnt + N + 2; c++) begin
      @(negedge clk);
      if (c >= 2 && c - 2 < cnt) begin
        chk(c_vld == 1'b1, "R6 comb valid", int'(c_vld), 1);
        chk(c_out == exp_med[c-2], {tag, " comb median"}, int'(c_out), int'(exp_med[c-2]));
      end else begin
        chk(c_vld == 1'b0, "R6 comb idle", int'(c_vld), 0);
      end
      if (c >= N + 1 && c - N - 1 < cnt) begin
        chk(p_vld == 1'b1, "R5 pipe valid", int'(p_vld), 1);
        chk(p_out == exp_med[c-N-1], {tag, " pipe median"}, int'(p_out), int'(exp_med[c-N-1]));
        chk(p_out[N-1] == exp_msb[c-N-1], "R4 pipe msb", int'(p_out[N-1]), int'(exp_msb[c-N-1]));
      end else begin
        chk(p_vld == 1'b0, "R5 pipe idle", int'(p_vld), 0);
      end
      if (c < cnt) begin
        smp_valid = 1'b1;
        smp_in    = stim[c];
      end else begin
        smp_valid = 1'b0;
      end
    end
  endtask

  // Serial evaluation; optionally disturbs it with a push and a second start.
  task automatic t_serial(input bit disturb, input logic [N-1:0] extra, input string tag);
    logic [N-1:0] e;
    e = ref_median();
    @(negedge clk);
    eval_start = 1'b1;
    @(negedge clk);
    eval_start = 1'b0;
    for (int c = 1; c <= N + 4; c++) begin
      if (c > 1) @(negedge clk);
      chk(s_vld == (c == N + 1), "R7 serial strobe", int'(s_vld), int'(c == N + 1));
      if (c == N + 1)
        chk(s_out == e, {tag, " serial median"}, int'(s_out), int'(e));
      if (!disturb) chk(p_vld == 1'b0, "R2 no sample no result", int'(p_vld), 0);
      smp_valid  = 1'b0;
      eval_start = 1'b0;
      if (disturb && c == 2) begin
        smp_valid  = 1'b1;
        smp_in     = extra;
        eval_start = 1'b1;
        model_push(extra);
      end
    end
    repeat (N + 2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; smp_in = '0; smp_valid = 1'b0; eval_start = 1'b0;
    for (int i = 0; i < M; i++) bw[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();

    // R3: general values with late-splitting prefixes
    stim[0] = 8'h3C; stim[1] = 8'hA1; stim[2] = 8'h07; stim[3] = 8'hFF;
    stim[4] = 8'h80; stim[5] = 8'h7F; stim[6] = 8'h81; stim[7] = 8'h10;
    stim[8] = 8'h10; stim[9] = 8'h55;
    t_stream(10, "R3");

    // R4: MSB column split three to two
    stim[0] = 8'h80; stim[1] = 8'h7F; stim[2] = 8'h81; stim[3] = 8'h00;
    stim[4] = 8'hFF; stim[5] = 8'h01; stim[6] = 8'h02;
    t_stream(7, "R4");

    // R8: repeated values and extremes
    stim[0] = 8'h42; stim[1] = 8'h42; stim[2] = 8'h42; stim[3] = 8'h42;
    stim[4] = 8'h42; stim[5] = 8'h00; stim[6] = 8'h00; stim[7] = 8'h00;
    stim[8] = 8'h00; stim[9] = 8'h00; stim[10] = 8'hFF; stim[11] = 8'hFF;
    stim[12] = 8'hFF; stim[13] = 8'hFF; stim[14] = 8'hFF; stim[15] = 8'h42;
    t_stream(16, "R8");

    stim[0] = 8'h90; stim[1] = 8'h0F; stim[2] = 8'h8F; stim[3] = 8'h91; stim[4] = 8'h10;
    t_stream(5, "R3");

    // R7: plain serial evaluation
    t_serial(1'b0, 8'h00, "R7");
    // R2: idle window evaluated again gives the same median
    t_serial(1'b0, 8'h00, "R2");
    // R7: push and second start during evaluation are ignored for this result
    t_serial(1'b1, 8'hEE, "R7");
    // R2: the pushed sample is now part of the window
    t_serial(1'b0, 8'h00, "R2");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule